// File: doc/BRIEF.md
# Logic Shift and Bit-Test Unit

This unit is the non-arithmetic datapath of an accumulator machine that works at either byte or full-word width. One request carries an operation code, a width choice, a target choice (accumulator or memory), the current accumulator, a memory operand and the incoming status flags. The unit forms bitwise logic results, shifts and rotates, increments and decrements, bit tests, and the set-bits and clear-bits read-modify-write forms. It returns the new accumulator and flag values together.

When the result belongs in memory, the unit emits it as a stream of byte writes. Each write carries an address offset, so an external address generator can add it to the operand address. A full-word write-back sends the upper byte first, then the lower byte. A byte-wide write-back is a single transfer. Requests use a valid/ready handshake. The request side is ready only when no write-back bytes are pending. The byte stream holds each byte, and the offset that goes with it, until the consumer raises ready. Stalling that consumer therefore back-pressures new requests.

Flags are packed as {N, V, Z, C} in bits 3 down to 0. Z is 1 when the relevant result is zero. In byte mode only bits 7..0 take part in the operation, and bit 7 is the sign bit.

Top module: `lsu_top`

## Requirements
- R1: Opcodes 0 (AND), 1 (OR) and 2 (XOR) combine the accumulator with the operand into the accumulator. In byte mode, accumulator bits 15..8 keep their old value. Z and N come from the result lane, and C and V are passed through unchanged.
- R2: Opcode 3 shifts left with a zero into bit 0, and the old lane MSB goes to C. Opcode 4 shifts right with a zero into the lane MSB, and the old bit 0 goes to C. Z and N come from the result, and V is passed through.
- R3: Opcode 5 rotates left, putting incoming C into bit 0 and taking outgoing C from the old lane MSB. Opcode 6 rotates right, putting incoming C into the lane MSB and taking outgoing C from the old bit 0.
- R4: Opcodes 7 (increment) and 8 (decrement) wrap within the lane and update only Z and N. C and V are passed through.
- R5: Opcode 9 (bit test) sets N from the operand lane MSB, V from the bit just below it, and Z when (accumulator AND operand) is zero in the lane. C is passed through. The accumulator is unchanged and nothing is written to memory.
- R6: Opcode 10 writes operand OR accumulator to memory, and opcode 11 writes operand AND NOT accumulator. Both set Z only when (accumulator AND operand) is zero in the lane. N, V and C are passed through, and the accumulator is unchanged. Both always target memory.
- R7: A full-word memory result is sent as two byte writes: offset 1 carrying bits 15..8, then offset 0 carrying bits 7..0. A byte-wide memory result is a single write at offset 0.
- R8: While wr_valid is high and wr_ready is low, wr_offset and wr_data stay stable. req_ready is low whenever write-back bytes are pending.
- R9: For opcodes 3 to 8, the target select picks accumulator (0) or memory (1). An accumulator-target operation raises no write. A memory-target operation returns the accumulator unchanged.
- R10: Opcodes 12 to 15 are unused. They pass the flags and the accumulator through unchanged and raise no write.
- R11: After reset, acc_out and flags_out are 0, wr_valid and res_valid are low, and req_ready is high.
- R12: res_valid is high for exactly the one cycle after a request is accepted, and acc_out and flags_out carry that request's results from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 4 | Operation code |
| req_wide | input | 1 | 1 = full word, 0 = byte |
| req_mem | input | 1 | Target select for shift/rotate/inc/dec (1 = memory) |
| req_acc | input | 16 | Current accumulator |
| req_opnd | input | 16 | Memory operand |
| req_flags | input | 4 | Incoming flags {N,V,Z,C} |
| acc_out | output | 16 | New accumulator |
| flags_out | output | 4 | New flags {N,V,Z,C} |
| res_valid | output | 1 | One-cycle pulse after acceptance |
| wr_valid | output | 1 | Write-back byte valid |
| wr_ready | input | 1 | Write-back consumer ready |
| wr_offset | output | 1 | Byte offset from operand address |
| wr_data | output | 8 | Write-back byte |

## Verification
A decode fault in the operation core shows up in acc_out or flags_out in the cycle right after acceptance. A wrong carry path is visible on C, and a misrouted target is visible as an unexpected write or a changed accumulator. A fault in the write-back sequencer's byte index or hold logic shows on wr_offset and wr_data in the first beat or under a stall. A fault in its busy state shows on req_ready within one beat. The bench therefore samples every output in the first cycle after acceptance, follows each beat, and holds the consumer stalled to expose any drift while the stream is waiting.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_SHL  = 4'd3,
    OP_SHR  = 4'd4,
    OP_RTL  = 4'd5,
    OP_RTR  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_TEST = 4'd9,
    OP_SETB = 4'd10,
    OP_CLRB = 4'd11
  } op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/lsu_core.sv
module lsu_core
  import lsu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op,
  input  logic              wide,
  input  logic              to_mem,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  flags_t            fin,
  output logic [DATA_W-1:0] acc_nxt,
  output flags_t            fout,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_val
);

  localparam int BYTE_W = 8;
  localparam logic [DATA_W-1:0] BYTE_MASK = DATA_W'({BYTE_W{1'b1}});
  localparam logic [DATA_W-1:0] TOP_WIDE  = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] TOP_BYTE  = DATA_W'(1) << (BYTE_W - 1);

  logic [DATA_W-1:0] mask, src, res, tmp, top_one;
  logic              src_msb, upd_zn, acc_wr;
  op_e               opc;

  always_comb begin
    opc     = op_e'(op);
    mask    = wide ? '1 : BYTE_MASK;
    top_one = wide ? TOP_WIDE : TOP_BYTE;
    src     = (to_mem ? opnd : acc) & mask;
    src_msb = wide ? src[DATA_W-1] : src[BYTE_W-1];
    res     = src;
    tmp     = '0;
    fout    = fin;
    upd_zn  = 1'b0;
    acc_wr  = 1'b0;
    wr_en   = 1'b0;
    case (opc)
      OP_AND: begin res = acc & opnd & mask;    acc_wr = 1'b1; upd_zn = 1'b1; end
      OP_OR:  begin res = (acc | opnd) & mask;  acc_wr = 1'b1; upd_zn = 1'b1; end
      OP_XOR: begin res = (acc ^ opnd) & mask;  acc_wr = 1'b1; upd_zn = 1'b1; end
      OP_SHL: begin res = (src << 1) & mask; fout.c = src_msb; end
      OP_SHR: begin res = src >> 1;          fout.c = src[0];  end
      OP_RTL: begin res = ((src << 1) | DATA_W'(fin.c)) & mask; fout.c = src_msb; end
      OP_RTR: begin res = (src >> 1) | (fin.c ? top_one : '0);  fout.c = src[0];  end
      OP_INC: res = (src + DATA_W'(1)) & mask;
      OP_DEC: res = (src - DATA_W'(1)) & mask;
      OP_TEST: begin
        tmp    = opnd & mask;
        fout.n = wide ? tmp[DATA_W-1] : tmp[BYTE_W-1];
        fout.v = wide ? tmp[DATA_W-2] : tmp[BYTE_W-2];
        fout.z = ((acc & opnd & mask) == '0);
      end
      OP_SETB: begin
        res    = (opnd | acc) & mask;
        wr_en  = 1'b1;
        fout.z = ((acc & opnd & mask) == '0);
      end
      OP_CLRB: begin
        res    = opnd & ~acc & mask;
        wr_en  = 1'b1;
        fout.z = ((acc & opnd & mask) == '0);
      end
      default: ;
    endcase
    // read-modify-write group: shifts, rotates, increment, decrement
    if (opc inside {OP_SHL, OP_SHR, OP_RTL, OP_RTR, OP_INC, OP_DEC}) begin
      upd_zn = 1'b1;
      if (to_mem) wr_en  = 1'b1;
      else        acc_wr = 1'b1;
    end
    if (upd_zn) begin
      fout.z = (res == '0);
      fout.n = wide ? res[DATA_W-1] : res[BYTE_W-1];
    end
    acc_nxt = acc_wr ? ((acc & ~mask) | res) : acc;
    wr_val  = res;
  end

endmodule

// File: rtl/lsu_wb_seq.sv
module lsu_wb_seq #(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide,
  input  logic [DATA_W-1:0] val,
  output logic              busy,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [OFF_W-1:0]  wr_offset,
  output logic [7:0]        wr_data
);

  localparam logic [OFF_W-1:0] LAST_LANE = OFF_W'(LANES - 1);

  logic [DATA_W-1:0] data_q;
  logic [OFF_W-1:0]  idx_q;
  logic              busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      data_q <= val;
      idx_q  <= wide ? LAST_LANE : '0;   // upper byte leaves first
    end else if (busy_q && wr_ready) begin
      if (idx_q == '0) busy_q <= 1'b0;
      else             idx_q  <= idx_q - OFF_W'(1);
    end
  end

  assign busy      = busy_q;
  assign wr_valid  = busy_q;
  assign wr_offset = idx_q;
  assign wr_data   = data_q[idx_q*8 +: 8];

  // R8: a stalled beat holds its content
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_offset) && $stable(wr_data)));

  // R7: a taken non-final beat is followed by the next lower offset
  p_desc_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_offset != '0) |=>
      (wr_valid && wr_offset == $past(wr_offset) - OFF_W'(1)));

  // R7: the final beat at offset zero ends the stream
  p_last_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_offset == '0 && !start) |=> !wr_valid);

endmodule

// File: rtl/lsu_top.sv
module lsu_top
  import lsu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic              req_wide,
  input  logic              req_mem,
  input  logic [DATA_W-1:0] req_acc,
  input  logic [DATA_W-1:0] req_opnd,
  input  logic [3:0]        req_flags,
  output logic [DATA_W-1:0] acc_out,
  output logic [3:0]        flags_out,
  output logic              res_valid,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [OFF_W-1:0]  wr_offset,
  output logic [7:0]        wr_data
);

  logic [DATA_W-1:0] acc_nxt, wr_val, acc_q;
  flags_t            f_nxt, f_q;
  logic              wr_en, busy, accept, rv_q;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  lsu_core #(.DATA_W(DATA_W)) u_core (
    .op      (req_op),
    .wide    (req_wide),
    .to_mem  (req_mem),
    .acc     (req_acc),
    .opnd    (req_opnd),
    .fin     (flags_t'(req_flags)),
    .acc_nxt (acc_nxt),
    .fout    (f_nxt),
    .wr_en   (wr_en),
    .wr_val  (wr_val)
  );

  lsu_wb_seq #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept && wr_en),
    .wide      (req_wide),
    .val       (wr_val),
    .busy      (busy),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_offset (wr_offset),
    .wr_data   (wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      f_q   <= '0;
      rv_q  <= 1'b0;
    end else begin
      rv_q <= accept;
      if (accept) begin
        acc_q <= acc_nxt;
        f_q   <= f_nxt;
      end
    end
  end

  assign acc_out   = acc_q;
  assign flags_out = f_q;
  assign res_valid = rv_q;

  // R8: no request is taken while bytes are pending
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !req_ready);

  // R5: bit test leaves the accumulator alone
  p_test_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == 4'd9) |=> (acc_out == $past(req_acc) && !wr_valid));

  // R4: increment and decrement pass carry and overflow
  p_incdec_cv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_op == 4'd7 || req_op == 4'd8)) |=>
      (flags_out[1:0] == $past(req_flags[1:0]) || 1'b0) && flags_out[2] == $past(req_flags[2]) ||
      (flags_out[0] == $past(req_flags[0]) && flags_out[2] == $past(req_flags[2])));

  // R10: unused codes are a pass-through
  p_unused_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op >= 4'd12) |=>
      (flags_out == $past(req_flags) && acc_out == $past(req_acc) && !wr_valid));

  // R9: logic ops on the accumulator start no write
  p_acc_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op <= 4'd2) |=> !wr_valid);

  // R12: result strobe lasts one cycle when no new request follows
  p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(accept, 2)) |-> $past(accept));

endmodule

// File: tb/lsu_top_tb.sv
module lsu_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_op = '0;
  logic        req_wide = 1'b0;
  logic        req_mem = 1'b0;
  logic [15:0] req_acc = '0;
  logic [15:0] req_opnd = '0;
  logic [3:0]  req_flags = '0;
  logic [15:0] acc_out;
  logic [3:0]  flags_out;
  logic        res_valid;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [0:0]  wr_offset;
  logic [7:0]  wr_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  lsu_top u_dut (.*);

  typedef struct packed {
    logic [3:0]  op;
    logic        wide;
    logic        mem;
    logic [15:0] acc;
    logic [15:0] opnd;
    logic [3:0]  fl;
    logic [15:0] eacc;
    logic [3:0]  efl;
    logic [1:0]  nb;
    logic [7:0]  bh;
    logic [7:0]  bl;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  1'b1, 1'b0, 16'hF0F0, 16'h0FF0, 4'h5, 16'h00F0, 4'h5, 2'd0, 8'h00, 8'h00, 4'd1},  // R1
    '{4'd1,  1'b0, 1'b0, 16'hAB00, 16'h0080, 4'h0, 16'hAB80, 4'h8, 2'd0, 8'h00, 8'h00, 4'd1},  // R1
    '{4'd2,  1'b0, 1'b0, 16'h12FF, 16'h34FF, 4'h0, 16'h1200, 4'h2, 2'd0, 8'h00, 8'h00, 4'd1},  // R1
    '{4'd3,  1'b1, 1'b0, 16'h8001, 16'h0000, 4'h0, 16'h0002, 4'h1, 2'd0, 8'h00, 8'h00, 4'd2},  // R2
    '{4'd3,  1'b0, 1'b0, 16'h5580, 16'h0000, 4'h0, 16'h5500, 4'h3, 2'd0, 8'h00, 8'h00, 4'd2},  // R2
    '{4'd4,  1'b1, 1'b1, 16'h1234, 16'h0003, 4'h8, 16'h1234, 4'h1, 2'd2, 8'h00, 8'h01, 4'd2},  // R2
    '{4'd5,  1'b0, 1'b1, 16'h0000, 16'h0080, 4'h1, 16'h0000, 4'h1, 2'd1, 8'h00, 8'h01, 4'd3},  // R3
    '{4'd6,  1'b1, 1'b0, 16'h0002, 16'h0000, 4'h1, 16'h8001, 4'h8, 2'd0, 8'h00, 8'h00, 4'd3},  // R3
    '{4'd6,  1'b0, 1'b0, 16'hFF01, 16'h0000, 4'h0, 16'hFF00, 4'h3, 2'd0, 8'h00, 8'h00, 4'd3},  // R3
    '{4'd7,  1'b1, 1'b0, 16'hFFFF, 16'h0000, 4'h1, 16'h0000, 4'h3, 2'd0, 8'h00, 8'h00, 4'd4},  // R4
    '{4'd8,  1'b0, 1'b1, 16'h7777, 16'h0000, 4'h4, 16'h7777, 4'hC, 2'd1, 8'h00, 8'hFF, 4'd4},  // R4
    '{4'd7,  1'b1, 1'b1, 16'h0000, 16'h00FF, 4'h0, 16'h0000, 4'h0, 2'd2, 8'h01, 8'h00, 4'd9},  // R9
    '{4'd9,  1'b1, 1'b0, 16'h00FF, 16'hC000, 4'h1, 16'h00FF, 4'hF, 2'd0, 8'h00, 8'h00, 4'd5},  // R5
    '{4'd9,  1'b0, 1'b0, 16'h0001, 16'h4001, 4'h8, 16'h0001, 4'h0, 2'd0, 8'h00, 8'h00, 4'd5},  // R5
    '{4'd10, 1'b1, 1'b1, 16'h00F0, 16'h0F0F, 4'hC, 16'h00F0, 4'hE, 2'd2, 8'h0F, 8'hFF, 4'd6},  // R6
    '{4'd11, 1'b0, 1'b1, 16'h0003, 16'h0007, 4'h2, 16'h0003, 4'h0, 2'd1, 8'h00, 8'h04, 4'd6},  // R6
    '{4'd13, 1'b1, 1'b1, 16'h1234, 16'h5555, 4'hA, 16'h1234, 4'hA, 2'd0, 8'h00, 8'h00, 4'd10}, // R10
    '{4'd3,  1'b1, 1'b1, 16'h0000, 16'h4000, 4'h0, 16'h0000, 4'h8, 2'd2, 8'h80, 8'h00, 4'd7}   // R7
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 acc",   acc_out, 16'h0);
    chk("R11 flags", 16'(flags_out), 16'h0);
    chk("R11 wr_valid", 16'(wr_valid), 16'h0);
    chk("R11 res_valid", 16'(res_valid), 16'h0);
    chk("R11 req_ready", 16'(req_ready), 16'h1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VEC[i].rq, i);
      req_op = VEC[i].op; req_wide = VEC[i].wide; req_mem = VEC[i].mem;
      req_acc = VEC[i].acc; req_opnd = VEC[i].opnd; req_flags = VEC[i].fl;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk({t, " acc"}, acc_out, VEC[i].eacc);
      chk({t, " flags"}, 16'(flags_out), 16'(VEC[i].efl));
      chk({t, " R12 res_valid"}, 16'(res_valid), 16'h1);
      if (VEC[i].nb == 2'd2) begin
        chk({t, " R7 hi valid"}, 16'(wr_valid), 16'h1);
        chk({t, " R7 hi off"}, 16'(wr_offset), 16'h1);
        chk({t, " R7 hi data"}, 16'(wr_data), 16'(VEC[i].bh));
        @(negedge clk);
        chk({t, " R12 pulse end"}, 16'(res_valid), 16'h0);
      end
      if (VEC[i].nb != 2'd0) begin
        chk({t, " R7 lo valid"}, 16'(wr_valid), 16'h1);
        chk({t, " R7 lo off"}, 16'(wr_offset), 16'h0);
        chk({t, " R7 lo data"}, 16'(wr_data), 16'(VEC[i].bl));
        @(negedge clk);
      end
      chk({t, " R9 no more writes"}, 16'(wr_valid), 16'h0);
      chk({t, " R8 ready"}, 16'(req_ready), 16'h1);
    end

    // R8: stalled consumer, full-word increment of memory
    wr_ready = 1'b0;
    req_op = 4'd7; req_wide = 1'b1; req_mem = 1'b1;
    req_acc = 16'hAAAA; req_opnd = 16'h1234; req_flags = 4'h0;
    req_valid = 1'b1;
    @(negedge clk);
    req_op = 4'd0;  // held request must not be taken while busy
    chk("R8 stall acc", acc_out, 16'hAAAA);
    for (int k = 0; k < 3; k++) begin
      chk("R8 stall valid", 16'(wr_valid), 16'h1);
      chk("R8 stall off", 16'(wr_offset), 16'h1);
      chk("R8 stall data", 16'(wr_data), 16'h0012);
      chk("R8 stall ready", 16'(req_ready), 16'h0);
      @(negedge clk);
      chk("R8 no accept", 16'(res_valid), 16'h0);
    end
    req_valid = 1'b0;
    wr_ready = 1'b1;
    @(negedge clk);
    chk("R7 after stall off", 16'(wr_offset), 16'h0);
    chk("R7 after stall data", 16'(wr_data), 16'h0035);
    chk("R8 acc kept", acc_out, 16'hAAAA);
    @(negedge clk);
    chk("R8 stream done", 16'(wr_valid), 16'h0);
    chk("R8 ready again", 16'(req_ready), 16'h1);

    finish_run();
  end

endmodule